// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in the transmit path ahead of the MAC. Each frame is preceded by a control header of five 32-bit words on a sideband stream. The frame bytes follow on a byte-wide data stream. The block stores the frame in an internal buffer. While the bytes arrive it accumulates a 16-bit ones-complement sum. After the last byte it can write the finished checksum back into the stored frame at an offset chosen per frame. It then plays the frame out on a byte-wide stream with valid/ready handshakes and an end-of-frame marker.

The block also applies two transmit policy rules when a frame ends. With transmit disabled, the frame is taken in and thrown away. With jumbo support off, a frame of 1519 to 1522 bytes is thrown away unless tagged frames are allowed. For every frame it sends, a 64-bit byte counter advances and a one-cycle completion pulse is raised.

Top module: `txcsum_inserter`

## Requirements
- R1: After reset, `mValid` is 0, `byteCount` is 0, `hdrReady` is 1 and `sReady` is 0.
- R2: A header is the run of words up to and including the word with `hdrLast`. Exactly five words are accepted, and the block then takes frame bytes. Any other count raises `hdrErr` for one cycle. That header is discarded, and the block keeps waiting for a header with `sReady` at 0.
- R3: When bit 0 of header word 0 is 0, the frame leaves byte for byte as it came in.
- R4: When bit 0 of header word 0 is 1, a checksum is computed as follows:
  - The start offset S is word 1 bits 31:16.
  - The bytes from index S to the end are summed as 16-bit words. The byte at index S+2k is the high half and the byte at S+2k+1 is the low half. An odd last byte is padded with a zero low half.
  - Word 2 bits 15:0 are added as a seed.
  - The carry is folded into the low 16 bits twice.
  - The result is inverted.
  - If S is at or beyond the frame end, the result is the inverted, folded seed.
- R5: The checksum high byte replaces the byte at the insert offset I (word 1 bits 15:0), and the low byte replaces the byte at I+1. A position at or beyond the frame end leaves the output unchanged.
- R6: With `cfgTxEnable` at 0, a frame is consumed and nothing is output. `byteCount` does not change and `txComplete` stays 0.
- R7: With `cfgJumbo` at 0 and `cfgVlan` at 0, a frame of 1519 to 1522 bytes is dropped as in R6. A 1518-byte frame is sent. If either bit is 1, those lengths are sent.
- R8: Each sent frame adds its length to `byteCount` and pulses `txComplete` for one cycle, in the cycle after its last output beat. `byteCount` changes at no other time.
- R9: Output bytes leave in order. `mLast` is 1 only on the final byte. `mData` and `mLast` hold while `mValid` is 1 and `mReady` is 0.
- R10: While a frame drains, `sReady` and `hdrReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTxEnable | input | 1 | Transmit enable |
| cfgJumbo | input | 1 | Jumbo frames allowed |
| cfgVlan | input | 1 | Tagged frame lengths allowed |
| hdrValid | input | 1 | Header word valid |
| hdrReady | output | 1 | Header word accepted |
| hdrData | input | 32 | Header word |
| hdrLast | input | 1 | Final header word |
| sValid | input | 1 | Input byte valid |
| sReady | output | 1 | Input byte accepted |
| sData | input | 8 | Input byte |
| sLast | input | 1 | Final input byte |
| mValid | output | 1 | Output byte valid |
| mReady | input | 1 | Output byte accepted |
| mData | output | 8 | Output byte |
| mLast | output | 1 | Final output byte |
| byteCount | output | 64 | Sent byte total |
| txComplete | output | 1 | Frame sent pulse |
| hdrErr | output | 1 | Malformed header pulse |

## Verification
Three events share one clock edge:
- the last output handshake of a frame;
- the byte counter update;
- the completion pulse.

The bench stresses this edge with random ready gaps on the output. In the cycle where the pulse is seen, it checks that the counter equals the prior total plus exactly the frame length.

A second overlap is inside the checksum region itself. The insert position often falls within the summed bytes. The expected frame is therefore built from the original bytes first and patched afterwards. This exposes a design that sums the patched values.

// File: rtl/txcsum_pkg.sv
package txcsum_pkg;
  localparam int HDR_WORDS = 5;
  localparam int VLAN_LEN_MIN = 1519;
  localparam int VLAN_LEN_MAX = 1522;

  typedef enum logic [2:0] {
    ST_HDR, ST_DATA, ST_FIN, ST_PATCH_HI, ST_PATCH_LO, ST_DRAIN
  } state_t;

  typedef struct packed {
    logic       hdrWe;
    logic [2:0] hdrIdx;
    logic       hdrBad;
    logic       frameStart;
    logic       byteWe;
    logic       finalize;
    logic       patchHi;
    logic       patchLo;
    logic       drainAdv;
    logic       frameDone;
  } strobe_t;
endpackage

// File: rtl/txcsum_ctrl.sv
module txcsum_ctrl
  import txcsum_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hdrValid,
  input  logic    hdrLast,
  input  logic    sValid,
  input  logic    sLast,
  input  logic    mReady,
  input  logic    keepFrame,
  input  logic    csumEnable,
  input  logic    lastOut,
  output logic    hdrReady,
  output logic    sReady,
  output logic    mValid,
  output strobe_t stb
);
  localparam logic [2:0] LAST_IDX = 3'(HDR_WORDS - 1);
  localparam logic [2:0] SAT_IDX  = 3'(HDR_WORDS);

  state_t state, stateNext;
  logic [2:0] hdrCnt;
  logic hdrFire;

  assign hdrReady = (state == ST_HDR);
  assign sReady   = (state == ST_DATA);
  assign mValid   = (state == ST_DRAIN);
  assign hdrFire  = hdrReady && hdrValid;

  always_comb begin
    stb = '0;
    stateNext = state;
    stb.hdrIdx = hdrCnt;
    case (state)
      ST_HDR: begin
        if (hdrFire && hdrCnt < SAT_IDX) stb.hdrWe = 1'b1;
        if (hdrFire && hdrLast) begin
          if (hdrCnt == LAST_IDX) begin
            stb.frameStart = 1'b1;
            stateNext = ST_DATA;
          end else begin
            stb.hdrBad = 1'b1;
          end
        end
      end
      ST_DATA: begin
        stb.byteWe = sValid;
        if (sValid && sLast) stateNext = ST_FIN;
      end
      ST_FIN: begin
        stb.finalize = 1'b1;
        if (!keepFrame)     stateNext = ST_HDR;
        else if (csumEnable) stateNext = ST_PATCH_HI;
        else                stateNext = ST_DRAIN;
      end
      ST_PATCH_HI: begin
        stb.patchHi = 1'b1;
        stateNext = ST_PATCH_LO;
      end
      ST_PATCH_LO: begin
        stb.patchLo = 1'b1;
        stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        stb.drainAdv  = mReady;
        stb.frameDone = mReady && lastOut;
        if (mReady && lastOut) stateNext = ST_HDR;
      end
      default: stateNext = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HDR;
      hdrCnt <= '0;
    end else begin
      state <= stateNext;
      if (hdrFire) begin
        if (hdrLast)               hdrCnt <= '0;
        else if (hdrCnt < SAT_IDX) hdrCnt <= hdrCnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/txcsum_dpath.sv
module txcsum_dpath
  import txcsum_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [31:0]      hdrData,
  input  logic [7:0]       sData,
  input  logic             cfgTxEnable,
  input  logic             cfgJumbo,
  input  logic             cfgVlan,
  output logic             keepFrame,
  output logic             csumEnable,
  output logic             lastOut,
  output logic [7:0]       mData,
  output logic [CNT_W-1:0] byteCount,
  output logic             txComplete,
  output logic             hdrErr
);
  localparam int PTR_W = $clog2(MAX_BYTES);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);
  localparam logic [LEN_W-1:0] TAG_MIN = LEN_W'(VLAN_LEN_MIN);
  localparam logic [LEN_W-1:0] TAG_MAX = LEN_W'(VLAN_LEN_MAX);
  localparam logic [16:0] MAX_POS = 17'(MAX_BYTES);

  logic [7:0] mem [MAX_BYTES];
  logic [15:0] startOff, insOff, seed, csumVal;
  logic [LEN_W-1:0] frameLen, rdPtr, sendLen;
  logic [31:0] sum, addend, seeded;
  logic [16:0] fold1;
  logic [15:0] fold2;
  logic inRange, sumHit, tagSized, insHiOk, insLoOk;
  logic [PTR_W-1:0] insIdx, insLoIdx;

  assign sendLen  = (frameLen > MAX_LEN) ? MAX_LEN : frameLen;
  assign inRange  = frameLen < MAX_LEN;
  assign sumHit   = inRange && (LEN_W'(startOff) <= frameLen);
  assign addend   = (frameLen[0] ^ startOff[0]) ? {24'h0, sData} : {16'h0, sData, 8'h0};
  assign seeded   = sum + {16'h0, seed};
  assign fold1    = {1'b0, seeded[31:16]} + {1'b0, seeded[15:0]};
  assign fold2    = fold1[15:0] + {15'h0, fold1[16]};
  assign tagSized = (frameLen >= TAG_MIN) && (frameLen <= TAG_MAX);
  assign keepFrame = cfgTxEnable && !(tagSized && !cfgJumbo && !cfgVlan);
  assign lastOut  = (rdPtr == sendLen - LEN_W'(1));
  assign mData    = mem[rdPtr[PTR_W-1:0]];
  assign insHiOk  = {1'b0, insOff} < MAX_POS;
  assign insLoOk  = ({1'b0, insOff} + 17'd1) < MAX_POS;
  assign insIdx   = insOff[PTR_W-1:0];
  assign insLoIdx = insIdx + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (stb.byteWe && inRange)          mem[frameLen[PTR_W-1:0]] <= sData;
    else if (stb.patchHi && insHiOk)    mem[insIdx]   <= csumVal[15:8];
    else if (stb.patchLo && insLoOk)    mem[insLoIdx] <= csumVal[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csumEnable <= 1'b0;
      startOff   <= '0;
      insOff     <= '0;
      seed       <= '0;
      csumVal    <= '0;
      frameLen   <= '0;
      rdPtr      <= '0;
      sum        <= '0;
      byteCount  <= '0;
      txComplete <= 1'b0;
      hdrErr     <= 1'b0;
    end else begin
      txComplete <= stb.frameDone;
      hdrErr     <= stb.hdrBad;
      if (stb.hdrWe) begin
        case (stb.hdrIdx)
          3'd0: csumEnable <= hdrData[0];
          3'd1: begin
            startOff <= hdrData[31:16];
            insOff   <= hdrData[15:0];
          end
          3'd2: seed <= hdrData[15:0];
          default: ;
        endcase
      end
      if (stb.frameStart) begin
        frameLen <= '0;
        rdPtr    <= '0;
        sum      <= '0;
      end
      if (stb.byteWe) begin
        if (frameLen != '1) frameLen <= frameLen + LEN_W'(1);
        if (sumHit) sum <= sum + addend;
      end
      if (stb.finalize)  csumVal <= ~fold2;
      if (stb.drainAdv)  rdPtr <= rdPtr + LEN_W'(1);
      if (stb.frameDone) byteCount <= byteCount + CNT_W'(sendLen);
    end
  end
endmodule

// File: rtl/txcsum_inserter.sv
module txcsum_inserter
  import txcsum_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgTxEnable,
  input  logic             cfgJumbo,
  input  logic             cfgVlan,
  input  logic             hdrValid,
  output logic             hdrReady,
  input  logic [31:0]      hdrData,
  input  logic             hdrLast,
  input  logic             sValid,
  output logic             sReady,
  input  logic [7:0]       sData,
  input  logic             sLast,
  output logic             mValid,
  input  logic             mReady,
  output logic [7:0]       mData,
  output logic             mLast,
  output logic [CNT_W-1:0] byteCount,
  output logic             txComplete,
  output logic             hdrErr
);
  strobe_t stb;
  logic keepFrame, csumEnable, lastOut;

  txcsum_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrLast(hdrLast),
    .sValid(sValid), .sLast(sLast), .mReady(mReady), .keepFrame(keepFrame),
    .csumEnable(csumEnable), .lastOut(lastOut), .hdrReady(hdrReady),
    .sReady(sReady), .mValid(mValid), .stb(stb)
  );

  txcsum_dpath #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hdrData(hdrData), .sData(sData),
    .cfgTxEnable(cfgTxEnable), .cfgJumbo(cfgJumbo), .cfgVlan(cfgVlan),
    .keepFrame(keepFrame), .csumEnable(csumEnable), .lastOut(lastOut),
    .mData(mData), .byteCount(byteCount), .txComplete(txComplete), .hdrErr(hdrErr)
  );

  assign mLast = mValid && lastOut;
endmodule

// File: rtl/txcsum_inserter_chk.sv
module txcsum_inserter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             hdrValid,
  input logic             hdrReady,
  input logic             hdrLast,
  input logic             sReady,
  input logic             mValid,
  input logic             mReady,
  input logic [7:0]       mData,
  input logic             mLast,
  input logic [CNT_W-1:0] byteCount,
  input logic             txComplete,
  input logic             hdrErr
);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> mValid && $stable(mData) && $stable(mLast));

  assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    mValid && mReady && mLast |=> !mValid);

  assert_input_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    mValid |-> !sReady && !hdrReady);

  assert_count_grows_R8: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> byteCount > $past(byteCount));

  assert_count_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txComplete |-> $stable(byteCount));

  assert_hdr_err_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |-> $past(hdrValid && hdrReady && hdrLast));
endmodule

bind txcsum_inserter txcsum_inserter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrReady(hdrReady),
  .hdrLast(hdrLast), .sReady(sReady), .mValid(mValid), .mReady(mReady),
  .mData(mData), .mLast(mLast), .byteCount(byteCount),
  .txComplete(txComplete), .hdrErr(hdrErr)
);

// File: tb/txcsum_inserter_tb.sv
`timescale 1ns/1ps
module txcsum_inserter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic cfgTxEnable = 1'b1, cfgJumbo = 1'b0, cfgVlan = 1'b0;
  logic hdrValid = 1'b0, hdrLast = 1'b0, sValid = 1'b0, sLast = 1'b0;
  logic [31:0] hdrData = '0;
  logic [7:0] sData = '0;
  logic mReady = 1'b1;
  logic hdrReady, sReady, mValid, mLast, txComplete, hdrErr;
  logic [7:0] mData;
  logic [63:0] byteCount;

  txcsum_inserter u_dut (
    .clk(clk), .rstN(rstN), .cfgTxEnable(cfgTxEnable), .cfgJumbo(cfgJumbo),
    .cfgVlan(cfgVlan), .hdrValid(hdrValid), .hdrReady(hdrReady),
    .hdrData(hdrData), .hdrLast(hdrLast), .sValid(sValid), .sReady(sReady),
    .sData(sData), .sLast(sLast), .mValid(mValid), .mReady(mReady),
    .mData(mData), .mLast(mLast), .byteCount(byteCount),
    .txComplete(txComplete), .hdrErr(hdrErr)
  );

  int checks = 0, fails = 0, cycles = 0;
  int completeCnt = 0, hdrErrCnt = 0, stallViol = 0;
  bit randReady = 1'b0;
  bit done = 1'b0;
  logic [7:0] gotQ[$];
  int lastPos[$];

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (txComplete) completeCnt++;
      if (hdrErr) hdrErrCnt++;
      if (mValid && (sReady || hdrReady)) stallViol++;
    end
    mReady = randReady ? (($urandom % 3) != 0) : 1'b1;
    if (rstN && mValid && mReady) begin
      gotQ.push_back(mData);
      if (mLast) lastPos.push_back(gotQ.size() - 1);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] refCsum(input logic [7:0] f[], input int st, input int sd);
    longint s = 0;
    for (int i = st; i < f.size(); i++)
      s += (((i - st) % 2) == 0) ? longint'(f[i]) * 256 : longint'(f[i]);
    s += sd;
    s = (s & 64'hffff) + (s >> 16);
    s = (s & 64'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic sendHeader(input logic [31:0] w0, w1, w2, input int n);
    for (int i = 0; i < n; i++) begin
      hdrValid = 1'b1;
      hdrData  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'hA5A5_0000 + i;
      hdrLast  = (i == n - 1);
      while (!hdrReady) @(negedge clk);
      @(negedge clk);
    end
    hdrValid = 1'b0;
    hdrLast  = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] f[], input bit gaps);
    for (int i = 0; i < f.size(); i++) begin
      if (gaps && ($urandom % 4) == 0) begin
        sValid = 1'b0;
        @(negedge clk);
      end
      sValid = 1'b1;
      sData  = f[i];
      sLast  = (i == f.size() - 1);
      while (!sReady) @(negedge clk);
      @(negedge clk);
    end
    sValid = 1'b0;
    sLast  = 1'b0;
  endtask

  task automatic runFrame(input bit en, jumbo, vlan, csum, input int st, ins, sd,
                          input logic [7:0] f[], input string req);
    logic [7:0] e[];
    logic [15:0] c;
    int len = f.size();
    bit keep;
    longint prevCnt;
    int prevComp;
    keep = en && !(!jumbo && !vlan && len >= 1519 && len <= 1522);
    e = f;
    if (csum) begin
      c = refCsum(f, st, sd);
      if (ins < len) e[ins] = c[15:8];
      if (ins + 1 < len) e[ins + 1] = c[7:0];
    end
    prevCnt = longint'(byteCount);
    prevComp = completeCnt;
    gotQ.delete();
    lastPos.delete();
    cfgTxEnable = en; cfgJumbo = jumbo; cfgVlan = vlan;
    sendHeader({31'h0, csum}, {st[15:0], ins[15:0]}, {16'h0, sd[15:0]}, 5);
    sendFrame(f, randReady);
    if (keep) begin
      while (completeCnt == prevComp) @(negedge clk);
      @(negedge clk);
      chk(gotQ.size() == len, req, "output length", gotQ.size(), len);
      begin
        int bad = -1;
        for (int i = 0; i < len && i < gotQ.size(); i++)
          if (bad < 0 && gotQ[i] !== e[i]) bad = i;
        chk(bad < 0, req, "first mismatching byte value",
            (bad < 0) ? 0 : gotQ[bad], (bad < 0) ? 0 : e[bad]);
      end
      chk(lastPos.size() == 1 && lastPos[0] == len - 1, "R9", "mLast position",
          (lastPos.size() > 0) ? lastPos[0] : -1, len - 1);
      chk(longint'(byteCount) == prevCnt + len, "R8", "byte counter",
          longint'(byteCount), prevCnt + len);
      chk(completeCnt == prevComp + 1, "R8", "completion pulses",
          completeCnt - prevComp, 1);
    end else begin
      repeat (10) @(negedge clk);
      chk(gotQ.size() == 0, req, "bytes out of dropped frame", gotQ.size(), 0);
      chk(longint'(byteCount) == prevCnt, req, "counter after drop",
          longint'(byteCount), prevCnt);
      chk(completeCnt == prevComp, req, "pulses after drop", completeCnt - prevComp, 0);
    end
  endtask

  function automatic void fillFrame(ref logic [7:0] f[], input int len, input int mode);
    f = new[len];
    for (int i = 0; i < len; i++)
      f[i] = (mode == 1) ? 8'hFF : 8'($urandom);
  endfunction

  initial begin
    logic [7:0] fr[];
    int unused;
    unused = $urandom(32'd20240607);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(mValid == 1'b0, "R1", "mValid", mValid, 0);
    chk(byteCount == 64'd0, "R1", "byteCount", longint'(byteCount), 0);
    chk(hdrReady == 1'b1 && sReady == 1'b0, "R1", "ready pair",
        {hdrReady, sReady}, 2);

    // R2: short and long headers rejected
    sendHeader(32'h1, 32'h0, 32'h0, 4);
    repeat (2) @(negedge clk);
    chk(hdrErrCnt == 1, "R2", "error after 4 words", hdrErrCnt, 1);
    chk(sReady == 1'b0, "R2", "sReady after bad header", sReady, 0);
    sendHeader(32'h1, 32'h0, 32'h0, 6);
    repeat (2) @(negedge clk);
    chk(hdrErrCnt == 2, "R2", "error after 6 words", hdrErrCnt, 2);
    chk(sReady == 1'b0 && hdrReady == 1'b1, "R2", "still awaiting header",
        {hdrReady, sReady}, 2);

    // R3: pass-through
    fillFrame(fr, 60, 0);
    runFrame(1, 0, 0, 0, 14, 20, 16'h1234, fr, "R3");
    // R4/R5: even and odd lengths
    fillFrame(fr, 64, 0);
    runFrame(1, 0, 0, 1, 14, 24, 16'h0000, fr, "R4");
    fillFrame(fr, 61, 0);
    runFrame(1, 0, 0, 1, 15, 16, 16'hBEEF, fr, "R4");
    // R4: start beyond end -> folded seed only
    fillFrame(fr, 40, 0);
    runFrame(1, 0, 0, 1, 100, 2, 16'h8001, fr, "R4");
    // R4: heavy carries
    fillFrame(fr, 90, 1);
    runFrame(1, 0, 0, 1, 0, 40, 16'hFFFF, fr, "R4");
    // R5: insert at last byte and beyond end
    fillFrame(fr, 33, 0);
    runFrame(1, 0, 0, 1, 4, 32, 16'h0F0F, fr, "R5");
    fillFrame(fr, 33, 0);
    runFrame(1, 0, 0, 1, 4, 300, 16'h0F0F, fr, "R5");
    // R6: transmit disabled
    fillFrame(fr, 50, 0);
    runFrame(0, 1, 1, 1, 0, 2, 16'h0, fr, "R6");
    // R7: length rules
    fillFrame(fr, 1519, 0);
    runFrame(1, 0, 0, 0, 0, 0, 0, fr, "R7");
    fillFrame(fr, 1522, 0);
    runFrame(1, 0, 0, 0, 0, 0, 0, fr, "R7");
    fillFrame(fr, 1518, 0);
    runFrame(1, 0, 0, 1, 14, 30, 16'h55AA, fr, "R7");
    fillFrame(fr, 1520, 0);
    runFrame(1, 0, 1, 0, 0, 0, 0, fr, "R7");
    fillFrame(fr, 1522, 0);
    runFrame(1, 1, 0, 1, 20, 1500, 16'h0101, fr, "R7");

    // random mix with backpressure and input gaps
    randReady = 1'b1;
    for (int n = 0; n < 24; n++) begin
      int len = 1 + int'($urandom % 150);
      int st  = int'($urandom % (len + 4));
      int ins = int'($urandom % (len + 2));
      int sd  = int'($urandom % 65536);
      bit cs  = ($urandom % 4) != 0;
      fillFrame(fr, len, 0);
      runFrame(1, 0, 0, cs, st, ins, sd, fr, cs ? "R5" : "R3");
    end
    randReady = 1'b0;

    chk(stallViol == 0, "R10", "ready while draining", stallViol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule